// File: doc/BRIEF.md
# Legacy UART Host Register File

This block is the byte-wide register bank that a host processor sees when it drives an old-style serial port. Eight offsets are selected by a 3-bit address with separate read and write strobes. Behind them sit a 16-bit baud divisor, an interrupt-enable byte, line control, modem control, a line status byte built from receive and transmit state, a writable modem status byte and a scratch byte. Reads are combinational from the address. Any side effect of a read takes place on the clock edge where the read strobe is sampled.

A serializer on the receive side offers whole bytes or break events through a side port and is told to wait while an unread byte is held. Writing the data offset hands one byte to a transmit serializer through a one-cycle strobe. The interrupt identification byte is produced by a neighbouring unit. It is read back through offset 2, and this block flags that read to that unit. The current enable, control, divisor and data-ready state are exported so that the interrupt and baud logic can use them.

Top module: `uart_host_regs`

## Requirements
- R1: Offset decode is 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch; a write to offsets 1, 3, 4, 6 or 7 (bank bit clear) reads back unchanged and appears on the matching output port.
- R2: After reset every stored register reads 0x00, line status reads 0x60 (bit 6 transmitter empty, bit 5 holding empty), rx_ready is 1 and tx_valid is 0.
- R3: With line control bit 7 set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8; such accesses start no transmission and do not clear data-ready.
- R4: A byte accepted from the receive port is returned by the next read of offset 0 and sets line status bit 0 (data-ready).
- R5: A read of offset 0 with the bank bit clear clears line status bits 0 and 4 from the next cycle on.
- R6: A break event loads the receive byte with 0x00 and sets line status bits 4 (break) and 0.
- R7: rx_ready is the inverse of data-ready; a byte or break offered while data-ready is set is dropped and the held byte is kept.
- R8: A write to offset 0 with the bank bit clear raises tx_valid for the next cycle with the written byte on tx_byte; line status bits 6 and 5 read 0 in that cycle and 1 in the cycle after.
- R9: With modem control bit 4 set, modem status reads {mctl[3:2], mctl[0], mctl[1], 4'b0000}; with it clear, the stored modem status is read.
- R10: Writes to offsets 2 and 5 change no register.
- R11: A read of offset 2 returns intr_id, and intr_id_rd is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, side effects on the sampling edge |
| rd_data | output | 8 | Combinational read byte |
| rx_valid | input | 1 | Received byte offered |
| rx_byte | input | 8 | Received byte |
| rx_brk | input | 1 | Break event offered |
| rx_ready | output | 1 | Receive holding register free |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte being handed to the transmitter |
| intr_id | input | 8 | Identification byte from the interrupt unit |
| intr_id_rd | output | 1 | Offset 2 is being read |
| divisor | output | 16 | Baud divisor |
| ier_out | output | 8 | Interrupt enable byte |
| lcr_out | output | 8 | Line control byte |
| mcr_out | output | 8 | Modem control byte |
| data_ready | output | 1 | Unread receive byte held |

## Verification
Read data and intr_id_rd are combinational, so they are due within the same cycle as the address and strobe. The bench samples them 1 ns after driving on the falling edge. Read, receive and write side effects land on the next rising edge. The bench therefore checks status, rx_ready and tx_valid at the falling edge that follows the strobe cycle. The transmit strobe lasts exactly one cycle, and line status bits 6:5 are checked both in that cycle and one falling edge later.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int BYTE_W    = 8;
  localparam int OFS_W     = 3;
  localparam int DIV_BYTES = 2;
  localparam int DIV_W     = DIV_BYTES * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [OFS_W-1:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_IID     = 3'd2,
    OFS_LCTL    = 3'd3,
    OFS_MCTL    = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  localparam int BANK_BIT = 7;
  localparam int LOOP_BIT = 4;

  // line status bit positions
  localparam int ST_DR   = 0;
  localparam int ST_BI   = 4;
  localparam int ST_THRE = 5;
  localparam int ST_TEMT = 6;

  // loopback: outputs 3:2 -> 7:6, request-to-send -> 4, terminal-ready -> 5
  function automatic byte_t loop_map(input byte_t mctl);
    return {mctl[3:2], mctl[0], mctl[1], 4'b0000};
  endfunction

endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import uart_regs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     ofs,
  input  byte_t                wr_data,
  output logic [DIV_W-1:0]     divisor,
  output byte_t                ier_q,
  output byte_t                lcr_q,
  output byte_t                mcr_q,
  output byte_t                msr_q,
  output byte_t                scr_q
);

  logic  bank;
  byte_t ier_d, lcr_d, mcr_d, msr_d, scr_d;

  assign bank = lcr_q[BANK_BIT];

  // divisor byte lanes live at offsets 0 and 1 when banked
  for (genvar g = 0; g < DIV_BYTES; g++) begin : g_div
    logic  lane_we;
    byte_t lane_d;
    byte_t lane_q;

    assign lane_we = wr_en && bank && (ofs == OFS_W'(g));

    always_comb begin
      lane_d = lane_q;
      if (lane_we) lane_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    assign divisor[g*BYTE_W +: BYTE_W] = lane_q;
  end

  always_comb begin
    ier_d = ier_q;
    lcr_d = lcr_q;
    mcr_d = mcr_q;
    msr_d = msr_q;
    scr_d = scr_q;
    if (wr_en) begin
      unique case (ofs)
        OFS_IEN:     if (!bank) ier_d = wr_data;
        OFS_LCTL:    lcr_d = wr_data;
        OFS_MCTL:    mcr_d = wr_data;
        OFS_MSTAT:   msr_d = wr_data;
        OFS_SCRATCH: scr_d = wr_data;
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q <= '0;
      lcr_q <= '0;
      mcr_q <= '0;
      msr_q <= '0;
      scr_q <= '0;
    end else begin
      ier_q <= ier_d;
      lcr_q <= lcr_d;
      mcr_q <= mcr_d;
      msr_q <= msr_d;
      scr_q <= scr_d;
    end
  end

  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (ofs == OFS_LSTAT || ofs == OFS_IID)) |=>
      ($stable(ier_q) && $stable(lcr_q) && $stable(mcr_q) && $stable(msr_q) && $stable(scr_q)))
    else $error("status write changed a register"); // R10

  AST_BANKED_IEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank && ofs == OFS_IEN) |=> $stable(ier_q))
    else $error("banked write reached enable byte"); // R3

endmodule

// File: rtl/uart_rx_hold.sv
module uart_rx_hold
  import uart_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rx_valid,
  input  byte_t rx_byte,
  input  logic  rx_brk,
  input  logic  data_rd,
  output byte_t rbr_q,
  output logic  dr_q,
  output logic  bi_q,
  output logic  rx_ready
);

  logic  accept;
  byte_t rbr_d;
  logic  dr_d, bi_d;

  assign rx_ready = !dr_q;
  assign accept   = (rx_valid || rx_brk) && !dr_q;

  always_comb begin
    rbr_d = rbr_q;
    dr_d  = dr_q;
    bi_d  = bi_q;
    if (data_rd) begin
      dr_d = 1'b0;
      bi_d = 1'b0;
    end
    if (accept) begin
      dr_d = 1'b1;
      if (rx_brk) begin
        rbr_d = '0;
        bi_d  = 1'b1;
      end else begin
        rbr_d = rx_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbr_q <= '0;
      dr_q  <= 1'b0;
      bi_q  <= 1'b0;
    end else begin
      rbr_q <= rbr_d;
      dr_q  <= dr_d;
      bi_q  <= bi_d;
    end
  end

  AST_FULL_HOLDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_valid || rx_brk) && dr_q) |=> $stable(rbr_q))
    else $error("held byte overwritten"); // R7

  AST_BRK_LOADS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_brk && rx_ready) |=> (rbr_q == '0 && bi_q && dr_q))
    else $error("break not captured"); // R6

  AST_BRK_WITH_DR: assert property (@(posedge clk) disable iff (!rst_n)
    bi_q |-> dr_q)
    else $error("break flag without data-ready"); // R6

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !accept) |=> (!dr_q && !bi_q))
    else $error("data read left status set"); // R5

  AST_BYTE_SETS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_brk && rx_ready) |=> (dr_q && rbr_q == $past(rx_byte)))
    else $error("received byte not captured"); // R4

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
  import uart_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  data_wr,
  input  byte_t wr_data,
  output logic  tx_valid,
  output byte_t tx_byte,
  output logic  hold_empty
);

  logic  pend_d, pend_q;
  byte_t byte_d, byte_q;

  always_comb begin
    pend_d = data_wr;
    byte_d = byte_q;
    if (data_wr) byte_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      byte_q <= '0;
    end else begin
      pend_q <= pend_d;
      byte_q <= byte_d;
    end
  end

  assign tx_valid   = pend_q;
  assign tx_byte    = byte_q;
  assign hold_empty = !pend_q;

  AST_TX_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (tx_valid && tx_byte == $past(wr_data)))
    else $error("write did not strobe transmitter"); // R8

  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !data_wr) |=> !tx_valid)
    else $error("transmit strobe stretched"); // R8

endmodule

// File: rtl/uart_read_mux.sv
module uart_read_mux
  import uart_regs_pkg::*;
(
  input  logic [OFS_W-1:0] ofs,
  input  logic [DIV_W-1:0] divisor,
  input  byte_t            rbr,
  input  byte_t            ier,
  input  byte_t            iid,
  input  byte_t            lcr,
  input  byte_t            mcr,
  input  byte_t            lsr,
  input  byte_t            msr,
  input  byte_t            scr,
  output byte_t            rd_data
);

  logic bank;
  assign bank = lcr[BANK_BIT];

  always_comb begin
    rd_data = '0;
    unique case (ofs)
      OFS_DATA:    rd_data = bank ? divisor[BYTE_W-1:0] : rbr;
      OFS_IEN:     rd_data = bank ? divisor[DIV_W-1:BYTE_W] : ier;
      OFS_IID:     rd_data = iid;
      OFS_LCTL:    rd_data = lcr;
      OFS_MCTL:    rd_data = mcr;
      OFS_LSTAT:   rd_data = lsr;
      OFS_MSTAT:   rd_data = mcr[LOOP_BIT] ? loop_map(mcr) : msr;
      OFS_SCRATCH: rd_data = scr;
      default:     rd_data = '0;
    endcase
  end

endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
  import uart_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_brk,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic [7:0]  intr_id,
  output logic        intr_id_rd,
  output logic [15:0] divisor,
  output logic [7:0]  ier_out,
  output logic [7:0]  lcr_out,
  output logic [7:0]  mcr_out,
  output logic        data_ready
);

  logic [OFS_W-1:0] ofs;
  logic  bank, data_rd, data_wr;
  byte_t ier_q, lcr_q, mcr_q, msr_q, scr_q, rbr_q, lsr;
  logic  dr_q, bi_q, hold_empty;

  assign ofs     = addr;
  assign bank    = lcr_q[BANK_BIT];
  assign data_rd = rd_en && (ofs == OFS_DATA) && !bank;
  assign data_wr = wr_en && (ofs == OFS_DATA) && !bank;

  uart_ctrl_regs i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .ofs     (ofs),
    .wr_data (wr_data),
    .divisor (divisor),
    .ier_q   (ier_q),
    .lcr_q   (lcr_q),
    .mcr_q   (mcr_q),
    .msr_q   (msr_q),
    .scr_q   (scr_q)
  );

  uart_rx_hold i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_brk   (rx_brk),
    .data_rd  (data_rd),
    .rbr_q    (rbr_q),
    .dr_q     (dr_q),
    .bi_q     (bi_q),
    .rx_ready (rx_ready)
  );

  uart_tx_hold i_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .data_wr    (data_wr),
    .wr_data    (wr_data),
    .tx_valid   (tx_valid),
    .tx_byte    (tx_byte),
    .hold_empty (hold_empty)
  );

  always_comb begin
    lsr          = '0;
    lsr[ST_DR]   = dr_q;
    lsr[ST_BI]   = bi_q;
    lsr[ST_THRE] = hold_empty;
    lsr[ST_TEMT] = hold_empty;
  end

  uart_read_mux i_mux (
    .ofs     (ofs),
    .divisor (divisor),
    .rbr     (rbr_q),
    .ier     (ier_q),
    .iid     (intr_id),
    .lcr     (lcr_q),
    .mcr     (mcr_q),
    .lsr     (lsr),
    .msr     (msr_q),
    .scr     (scr_q),
    .rd_data (rd_data)
  );

  assign intr_id_rd = rd_en && (ofs == OFS_IID);
  assign ier_out    = ier_q;
  assign lcr_out    = lcr_q;
  assign mcr_out    = mcr_q;
  assign data_ready = dr_q;

  AST_NO_TX_BANKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bank && ofs == OFS_DATA) |=> !tx_valid)
    else $error("banked write started a transmission"); // R3

  AST_BANKED_RD_KEEPS_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bank && ofs == OFS_DATA && dr_q) |=> dr_q)
    else $error("banked read cleared data-ready"); // R3

  AST_RX_READY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> !rx_ready)
    else $error("receiver open while byte held"); // R7

endmodule

// File: tb/test_uart_host_regs.sv
`timescale 1ns/1ps
module test_uart_host_regs;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  addr;
  logic        wr_en, rd_en;
  logic [7:0]  wr_data, rd_data;
  logic        rx_valid, rx_brk, rx_ready;
  logic [7:0]  rx_byte;
  logic        tx_valid;
  logic [7:0]  tx_byte;
  logic [7:0]  intr_id;
  logic        intr_id_rd;
  logic [15:0] divisor;
  logic [7:0]  ier_out, lcr_out, mcr_out;
  logic        data_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  uart_host_regs i_uart_host_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_brk(rx_brk), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .intr_id(intr_id), .intr_id_rd(intr_id_rd), .divisor(divisor),
    .ier_out(ier_out), .lcr_out(lcr_out), .mcr_out(mcr_out),
    .data_ready(data_ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic rx_send(input logic [7:0] b, input logic brk);
    rx_byte = b; rx_valid = !brk; rx_brk = brk;
    @(negedge clk);
    rx_valid = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      if (a == 2 || a == 5) continue;
      peek(3'(a), v);
      chk($sformatf("R2 offset %0d after reset", a), v, 8'h00);
    end
    peek(3'd5, v);
    chk("R2 line status after reset", v, 8'h60);
    chk("R2 rx_ready after reset", rx_ready, 1);
    chk("R2 tx_valid after reset", tx_valid, 0);
    chk("R2 divisor after reset", divisor, 16'h0000);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(3'd1, 8'h0F);
    wr(3'd3, 8'h1B);
    wr(3'd4, 8'h0A);
    wr(3'd7, 8'hC3);
    rd(3'd1, v); chk("R1 enable readback", v, 8'h0F);
    rd(3'd3, v); chk("R1 line control readback", v, 8'h1B);
    rd(3'd4, v); chk("R1 modem control readback", v, 8'h0A);
    rd(3'd7, v); chk("R1 scratch readback", v, 8'hC3);
    chk("R1 ier_out port", ier_out, 8'h0F);
    chk("R1 lcr_out port", lcr_out, 8'h1B);
    chk("R1 mcr_out port", mcr_out, 8'h0A);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFF);
    peek(3'd5, v); chk("R10 line status after write", v, 8'h60);
    peek(3'd7, v); chk("R10 scratch kept", v, 8'hC3);
    peek(3'd1, v); chk("R10 enable kept", v, 8'h0F);
    peek(3'd3, v); chk("R10 line control kept", v, 8'h1B);
    peek(3'd4, v); chk("R10 modem control kept", v, 8'h0A);
    chk("R10 no transmit", tx_valid, 0);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    rx_send(8'hA5, 1'b0);
    peek(3'd5, v); chk("R4 data-ready set", v, 8'h61);
    chk("R7 rx_ready low while held", rx_ready, 0);
    rx_send(8'h3C, 1'b0);
    rx_send(8'h00, 1'b1);
    rd(3'd0, v); chk("R7 held byte kept, R4 byte read", v, 8'hA5);
    peek(3'd5, v); chk("R5 read clears data-ready", v, 8'h60);
    chk("R7 rx_ready high after read", rx_ready, 1);
    rx_send(8'h3C, 1'b0);
    rd(3'd0, v); chk("R4 second byte", v, 8'h3C);
  endtask

  task automatic t_break();
    logic [7:0] v;
    rx_send(8'h77, 1'b1);
    peek(3'd5, v); chk("R6 break and data-ready set", v, 8'h71);
    chk("R6 data_ready port", data_ready, 1);
    rd(3'd0, v); chk("R6 break byte is zero", v, 8'h00);
    peek(3'd5, v); chk("R5 read clears break", v, 8'h60);
  endtask

  task automatic t_divisor();
    logic [7:0] v;
    wr(3'd3, 8'h83);
    wr(3'd0, 8'h34);
    chk("R3 banked write no transmit", tx_valid, 0);
    wr(3'd1, 8'h12);
    chk("R3 divisor port", divisor, 16'h1234);
    rx_send(8'h55, 1'b0);
    rd(3'd0, v); chk("R3 divisor low read", v, 8'h34);
    rd(3'd1, v); chk("R3 divisor high read", v, 8'h12);
    peek(3'd5, v); chk("R3 banked read keeps data-ready", v, 8'h61);
    wr(3'd3, 8'h03);
    rd(3'd1, v); chk("R3 enable visible when unbanked", v, 8'h0F);
    rd(3'd0, v); chk("R3 receive byte visible when unbanked", v, 8'h55);
    chk("R3 divisor held", divisor, 16'h1234);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr(3'd0, 8'h5A);
    chk("R8 tx_valid in cycle after write", tx_valid, 1);
    chk("R8 tx_byte", tx_byte, 8'h5A);
    peek(3'd5, v); chk("R8 empty bits low during handoff", v, 8'h00);
    @(negedge clk);
    chk("R8 tx_valid single cycle", tx_valid, 0);
    peek(3'd5, v); chk("R8 empty bits restored", v, 8'h60);
  endtask

  task automatic t_loop();
    logic [7:0] v;
    wr(3'd6, 8'h5A);
    wr(3'd4, 8'h1B);
    peek(3'd6, v); chk("R9 loopback map 0x1B", v, 8'hB0);
    wr(3'd4, 8'h16);
    peek(3'd6, v); chk("R9 loopback map 0x16", v, 8'h50);
    wr(3'd4, 8'h05);
    peek(3'd6, v); chk("R9 stored modem status", v, 8'h5A);
  endtask

  task automatic t_iid();
    logic [7:0] v;
    intr_id = 8'hC4;
    addr = 3'd2; rd_en = 1'b1;
    #1 v = rd_data;
    chk("R11 identification read", v, 8'hC4);
    chk("R11 intr_id_rd during read", intr_id_rd, 1);
    @(negedge clk);
    rd_en = 1'b0;
    #1 chk("R11 intr_id_rd after read", intr_id_rd, 0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    rx_valid = 1'b0; rx_brk = 1'b0; rx_byte = '0; intr_id = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ignored();
    t_rx();
    t_break();
    t_divisor();
    t_tx();
    t_loop();
    t_iid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: requirement all, actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule